// File: doc/BRIEF.md
# Interrupt Global Control Unit

This block holds the processor's global interrupt control register. The register has two live bits: a global enable and an in-service flag. The block combines them with the pending request from the peripheral sources and produces the single interrupt request seen by the core. Vector generation, per-source masking and priority arbitration are handled elsewhere.

When the core acknowledges an interrupt, the in-service flag is set. While it stays set, every further request is blocked. A service routine can clear the flag by a register write, which allows a higher event to nest. If the routine leaves the flag set, the return-from-interrupt strobe clears it.

The request output is a flop. It follows its inputs one clock later. The register value is presented continuously on a read-data port, and its upper bits always read zero.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After synchronous reset, `reg_rdata` is all zeros and `cpu_irq` is 0.
- R2: A clock edge with `reg_we` high loads bit 0 of `reg_wdata` into the enable bit, which reads back on `reg_rdata[0]`.
- R3: `reg_rdata` bits above bit 1 read 0 at all times, whatever value is written.
- R4: A clock edge with `irq_ack` high sets the in-service bit, which reads back on `reg_rdata[1]`.
- R5: A clock edge with `irq_return` high and `irq_ack` low clears the in-service bit.
- R6: A clock edge with `reg_we` high and both `irq_ack` and `irq_return` low loads `reg_wdata[1]` into the in-service bit. Writing 0 permits nesting.
- R7: The in-service bit has a fixed priority on a single edge. Acknowledge wins over return and write. Return wins over write.
- R8: `cpu_irq` after a clock edge equals enable AND (NOT in-service) AND `irq_pending`, all three sampled before that edge. A cleared enable bit or a set in-service bit therefore blocks the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pending | input | 1 | Some peripheral source has a pending interrupt |
| irq_ack | input | 1 | Core acknowledges an interrupt this cycle |
| irq_return | input | 1 | Core executes an interrupt return this cycle |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| cpu_irq | output | 1 | Registered interrupt request to the core |
| reg_rdata | output | DATA_W | Current register value |

## Verification
The assertions assume that reset is held for at least one edge before any strobe is used. They also assume that the strobes are sampled as clean single-cycle levels on the clock edge. No assumption is made about whether acknowledge, return and write are mutually exclusive.

The stimulus drives every input only on the falling edge. It walks all four starting register states against every combination of the three strobes, the pending input and the two live write-data bits, with the upper write-data bits varied. Simultaneous strobes are therefore included on purpose rather than excluded.

// File: rtl/irqgc_pkg.sv
package irqgc_pkg;
  localparam int unsigned EN_POS  = 0;
  localparam int unsigned INS_POS = 1;
  localparam int unsigned LIVE_W  = 2;

  typedef struct packed {
    logic ins;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    INS_HOLD  = 2'd0,
    INS_SET   = 2'd1,
    INS_CLEAR = 2'd2,
    INS_LOAD  = 2'd3
  } ins_op_e;
endpackage

// File: rtl/irqgc_ctrl_reg.sv
module irqgc_ctrl_reg
  import irqgc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_ack,
  input  logic              irq_return,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output ctrl_t             ctrl_q
);
  localparam int unsigned PAD_W = DATA_W - LIVE_W;

  ins_op_e ins_op;
  logic    unused_hi;

  // Fixed priority for the in-service bit: acknowledge, then return, then write.
  always_comb begin
    if (irq_ack)         ins_op = INS_SET;
    else if (irq_return) ins_op = INS_CLEAR;
    else if (reg_we)     ins_op = INS_LOAD;
    else                 ins_op = INS_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (reg_we) ctrl_q.en <= reg_wdata[EN_POS];
      unique case (ins_op)
        INS_SET:   ctrl_q.ins <= 1'b1;
        INS_CLEAR: ctrl_q.ins <= 1'b0;
        INS_LOAD:  ctrl_q.ins <= reg_wdata[INS_POS];
        default:   ctrl_q.ins <= ctrl_q.ins;
      endcase
    end
  end

  // Reserved write bits carry no state.
  assign unused_hi = ^reg_wdata[DATA_W-1 -: PAD_W];
endmodule

// File: rtl/irqgc_req_gate.sv
module irqgc_req_gate
  import irqgc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl_q,
  input  logic  irq_pending,
  output logic  cpu_irq
);
  logic allow;

  assign allow = ctrl_q.en & ~ctrl_q.ins;

  always_ff @(posedge clk) begin
    if (rst) cpu_irq <= 1'b0;
    else     cpu_irq <= allow & irq_pending;
  end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
  import irqgc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_pending,
  input  logic              irq_ack,
  input  logic              irq_return,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              cpu_irq,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned PAD_W = DATA_W - LIVE_W;

  ctrl_t ctrl_q;

  irqgc_ctrl_reg #(.DATA_W(DATA_W)) reg_i (
    .clk        (clk),
    .rst        (rst),
    .irq_ack    (irq_ack),
    .irq_return (irq_return),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .ctrl_q     (ctrl_q)
  );

  irqgc_req_gate gate_i (
    .clk         (clk),
    .rst         (rst),
    .ctrl_q      (ctrl_q),
    .irq_pending (irq_pending),
    .cpu_irq     (cpu_irq)
  );

  assign reg_rdata = {{PAD_W{1'b0}}, ctrl_q.ins, ctrl_q.en};
endmodule

// File: rtl/irqgc_chk.sv
module irqgc_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_pending,
  input logic              irq_ack,
  input logic              irq_return,
  input logic              reg_we,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              cpu_irq,
  input logic [DATA_W-1:0] reg_rdata
);
  // R2
  en_load_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> reg_rdata[0] == $past(reg_wdata[0]));
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:2] == '0);
  // R4
  ack_sets_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> reg_rdata[1]);
  // R5
  ret_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_return && !irq_ack) |=> !reg_rdata[1]);
  // R6
  sw_ins_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !irq_ack && !irq_return) |=> reg_rdata[1] == $past(reg_wdata[1]));
  // R8
  req_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ##1 (cpu_irq == $past(reg_rdata[0] & ~reg_rdata[1] & irq_pending)));
endmodule

bind irq_gate_ctrl irqgc_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .irq_pending (irq_pending),
  .irq_ack     (irq_ack),
  .irq_return  (irq_return),
  .reg_we      (reg_we),
  .reg_wdata   (reg_wdata),
  .cpu_irq     (cpu_irq),
  .reg_rdata   (reg_rdata)
);

// File: tb/irq_gate_ctrl_tb_top.sv
module irq_gate_ctrl_tb_top;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          irq_pending = 1'b0;
  logic          irq_ack = 1'b0;
  logic          irq_return = 1'b0;
  logic          reg_we = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic          cpu_irq;
  logic [DW-1:0] reg_rdata;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  logic m_en  = 1'b0;
  logic m_ins = 1'b0;
  logic m_irq = 1'b0;

  always #2 clk = ~clk;

  irq_gate_ctrl #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .irq_pending(irq_pending), .irq_ack(irq_ack),
    .irq_return(irq_return), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .cpu_irq(cpu_irq), .reg_rdata(reg_rdata)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic p, input logic a, input logic r,
                      input logic w, input logic [DW-1:0] d);
    string tag;
    @(negedge clk);
    irq_pending = p; irq_ack = a; irq_return = r; reg_we = w; reg_wdata = d;
    @(posedge clk);
    m_irq = m_en & ~m_ins & p;
    if (w) m_en = d[0];
    if (a)      m_ins = 1'b1;
    else if (r) m_ins = 1'b0;
    else if (w) m_ins = d[1];
    if (a && (r || w))  tag = "R7";
    else if (a)         tag = "R4";
    else if (r && w)    tag = "R7";
    else if (r)         tag = "R5";
    else if (w)         tag = "R6";
    else                tag = "R4 hold";
    #1;
    check("R2 enable", {{(DW-1){1'b0}}, reg_rdata[0]}, {{(DW-1){1'b0}}, m_en});
    check(tag, {{(DW-1){1'b0}}, reg_rdata[1]}, {{(DW-1){1'b0}}, m_ins});
    check("R3 reserved", {2'b00, reg_rdata[DW-1:2]}, '0);
    check("R8 request", {{(DW-1){1'b0}}, cpu_irq}, {{(DW-1){1'b0}}, m_irq});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 rdata", reg_rdata, '0);
    check("R1 irq", {{(DW-1){1'b0}}, cpu_irq}, '0);
    @(negedge clk);
    rst = 1'b0;

    for (int st = 0; st < 4; st++) begin
      for (int c = 0; c < 256; c++) begin
        logic [7:0] cv;
        cv = c[7:0];
        step(1'b0, 1'b0, 1'b0, 1'b1, {6'h2A ^ {3{cv[7:6]}}, st[1:0]});
        step(cv[0], cv[1], cv[2], cv[3],
             {cv[7:6], 4'b1011 ^ {cv[7:6], cv[7:6]}, cv[5:4]});
      end
    end

    // R7 directed: acknowledge together with a write that clears in-service
    step(1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
    step(1'b1, 1'b1, 1'b0, 1'b1, 8'hFD);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    // R8 nesting: software clears in-service, request passes next cycle
    step(1'b1, 1'b0, 1'b0, 1'b1, 8'h01);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule